// File: doc/BRIEF.md
# Two-Phase Power-On Reset Sequencer

This block drives two active-low control lines into a bridge device. One is a power-on indication and the other is a bus reset. It also drives a flag that says the device may now be configured. The sequencer waits for an asynchronous power-good level and passes it through a two-flop synchronizer. It then walks a fixed timed sequence:

1. A minimum reset hold.
2. Release of power-on.
3. Release of bus reset.
4. A long quiet gap.
5. A second power-on pulse, with bus reset pulled low again.
6. A second release of both lines.
7. After a settling delay, the configuration-ready flag.

A free-running reference clock of known frequency runs the block. Every interval is given in microseconds and turned into a cycle count from the clock-frequency parameter, rounded up, so each minimum is always met. All three outputs come straight from flops, so they cannot glitch. If power-good is lost at any point, both lines are pulled active, the ready flag is cleared and the sequence starts again from the reset hold.

Top module: `por_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until the sequence advances, `pwr_on_n`, `bus_rst_n` and `cfg_ready` are all 0.
- R2: `pwr_on_n` goes to 1 exactly HOLD+2 clock edges after `pwr_good` rises. HOLD comes from `HOLD_US`; the extra 2 edges are the synchronizer.
- R3: `bus_rst_n` goes to 1 exactly REL cycles (from `REL_US`) after the first `pwr_on_n` release. It never rises while `pwr_on_n` is 0.
- R4: `pwr_on_n` returns to 0 exactly GAP cycles (from `GAP_US`) after `bus_rst_n` is released. `bus_rst_n` returns to 0 on the same edge.
- R5: The second power-on pulse keeps `pwr_on_n` at 0 for exactly PULSE cycles (from `PULSE_US`). `bus_rst_n` stays 0 throughout the pulse.
- R6: After the second pulse, `bus_rst_n` goes to 1 again exactly REL cycles after `pwr_on_n` returns to 1.
- R7: `cfg_ready` goes to 1 exactly CFG cycles (from `CFG_US`) after the final `bus_rst_n` release. It stays 1 while power-good holds, and it is 1 only while both lines are 1.
- R8: When `pwr_good` falls, all three outputs are 0 on the third clock edge after the fall. The sequence then restarts with the reset hold.
- R9: Each interval in cycles is ceil(us × CLK_KHZ / 1000), with a minimum of 1. For example, 3 µs at 1500 kHz gives 5 cycles.
- R10: `pwr_good` passes through two flops. On the first two edges after a drop, the outputs keep following the sequence as if power-good were still high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Asynchronous power-stable level |
| pwr_on_n | output | 1 | Active-low power-on indication to the bridge |
| bus_rst_n | output | 1 | Active-low bus reset to the bridge |
| cfg_ready | output | 1 | High when configuration cycles may begin |

## Verification
The assertions assume the following about the inputs:
- `pwr_good` may change at any time, with no relation to `clk`.
- `rst_n` is applied once at start-up.

Under these assumptions, the timing minimums must hold on every path, including restarts after a loss. The interval counters in the checker count only from observed output edges, so they make no assumption about which state the sequence is in.

The bench holds to the same assumptions. It drives `pwr_good` only on falling clock edges and keeps it low for several cycles before each restart. It then sweeps the drop instant across every cycle of the sequence. At each instant it checks the output pattern just before the drop, two edges after it and three edges after it.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_WAIT_REL,
    ST_GAP,
    ST_PULSE,
    ST_FINAL,
    ST_CFG,
    ST_READY
  } seq_state_e;

  typedef enum logic [2:0] {
    IV_HOLD,
    IV_REL,
    IV_GAP,
    IV_PULSE,
    IV_CFG
  } ival_e;

  // Cycles covering at least 'us' microseconds at 'khz' kilohertz, rounded up.
  function automatic longint unsigned us_to_cycles(input longint unsigned us,
                                                   input longint unsigned khz);
    longint unsigned prod;
    longint unsigned cyc;
    prod = us * khz;
    cyc  = (prod + 64'd999) / 64'd1000;
    return (cyc == 64'd0) ? 64'd1 : cyc;
  endfunction

  function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Output pattern {pwr_on_n, bus_rst_n, cfg_ready} for a given state.
  function automatic logic [2:0] state_outputs(input seq_state_e s);
    logic [2:0] o;
    unique case (s)
      ST_WAIT_REL, ST_FINAL: o = 3'b100;
      ST_GAP, ST_CFG:        o = 3'b110;
      ST_READY:              o = 3'b111;
      default:               o = 3'b000;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/por_sync_chain.sv
module por_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/por_interval_timer.sv
module por_interval_timer
  import por_seq_pkg::*;
#(
  parameter int unsigned W         = 4,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned REL_CYC   = 1,
  parameter int unsigned GAP_CYC   = 1,
  parameter int unsigned PULSE_CYC = 1,
  parameter int unsigned CFG_CYC   = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  ival_e sel,
  output logic  done
);
  logic [W-1:0] cnt;
  logic [W-1:0] reload;

  // Loading N-1 makes the owning state last exactly N cycles.
  always_comb begin
    unique case (sel)
      IV_HOLD:  reload = W'(HOLD_CYC - 1);
      IV_REL:   reload = W'(REL_CYC - 1);
      IV_GAP:   reload = W'(GAP_CYC - 1);
      IV_PULSE: reload = W'(PULSE_CYC - 1);
      IV_CFG:   reload = W'(CFG_CYC - 1);
      default:  reload = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= reload;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/por_seq_fsm.sv
module por_seq_fsm
  import por_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pg_s,
  input  logic  tmr_done,
  output logic  tmr_load,
  output ival_e tmr_sel,
  output logic  pwr_on_n,
  output logic  bus_rst_n,
  output logic  cfg_ready
);
  seq_state_e state, nxt;
  logic [2:0] out_d;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_sel  = IV_HOLD;
    if (state == ST_IDLE || !pg_s) begin
      nxt      = ST_HOLD;
      tmr_load = 1'b1;
    end else if (tmr_done) begin
      unique case (state)
        ST_HOLD:     begin nxt = ST_WAIT_REL; tmr_load = 1'b1; tmr_sel = IV_REL;   end
        ST_WAIT_REL: begin nxt = ST_GAP;      tmr_load = 1'b1; tmr_sel = IV_GAP;   end
        ST_GAP:      begin nxt = ST_PULSE;    tmr_load = 1'b1; tmr_sel = IV_PULSE; end
        ST_PULSE:    begin nxt = ST_FINAL;    tmr_load = 1'b1; tmr_sel = IV_REL;   end
        ST_FINAL:    begin nxt = ST_CFG;      tmr_load = 1'b1; tmr_sel = IV_CFG;   end
        ST_CFG:      nxt = ST_READY;
        default:     nxt = state;
      endcase
    end
  end

  assign out_d = state_outputs(nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pwr_on_n  <= 1'b0;
      bus_rst_n <= 1'b0;
      cfg_ready <= 1'b0;
    end else begin
      state     <= nxt;
      pwr_on_n  <= out_d[2];
      bus_rst_n <= out_d[1];
      cfg_ready <= out_d[0];
    end
  end
endmodule

// File: rtl/por_seq.sv
module por_seq
  import por_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ  = 100000,
  parameter int unsigned HOLD_US  = 1000,
  parameter int unsigned REL_US   = 15,
  parameter int unsigned GAP_US   = 16000,
  parameter int unsigned PULSE_US = 1000,
  parameter int unsigned CFG_US   = 32000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic pwr_on_n,
  output logic bus_rst_n,
  output logic cfg_ready
);
  localparam int unsigned HOLD_CYC  = 32'(us_to_cycles(64'(HOLD_US),  64'(CLK_KHZ)));
  localparam int unsigned REL_CYC   = 32'(us_to_cycles(64'(REL_US),   64'(CLK_KHZ)));
  localparam int unsigned GAP_CYC   = 32'(us_to_cycles(64'(GAP_US),   64'(CLK_KHZ)));
  localparam int unsigned PULSE_CYC = 32'(us_to_cycles(64'(PULSE_US), 64'(CLK_KHZ)));
  localparam int unsigned CFG_CYC   = 32'(us_to_cycles(64'(CFG_US),   64'(CLK_KHZ)));
  localparam int unsigned MAX_CYC   =
    cyc_max(cyc_max(cyc_max(HOLD_CYC, REL_CYC), cyc_max(GAP_CYC, PULSE_CYC)), CFG_CYC);
  localparam int unsigned TMR_W     = $clog2(MAX_CYC + 1);

  // Named internal events, also observed by the bound checker.
  logic  pg_s;
  logic  tmr_load;
  logic  tmr_done;
  ival_e tmr_sel;

  por_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pwr_good),
    .q     (pg_s)
  );

  por_interval_timer #(
    .W         (TMR_W),
    .HOLD_CYC  (HOLD_CYC),
    .REL_CYC   (REL_CYC),
    .GAP_CYC   (GAP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .CFG_CYC   (CFG_CYC)
  ) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .sel   (tmr_sel),
    .done  (tmr_done)
  );

  por_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pg_s      (pg_s),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .tmr_sel   (tmr_sel),
    .pwr_on_n  (pwr_on_n),
    .bus_rst_n (bus_rst_n),
    .cfg_ready (cfg_ready)
  );
endmodule

// File: rtl/por_seq_chk.sv
module por_seq_chk #(
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned REL_CYC   = 1,
  parameter int unsigned GAP_CYC   = 1,
  parameter int unsigned PULSE_CYC = 1,
  parameter int unsigned CFG_CYC   = 1
) (
  input logic clk,
  input logic rst_n,
  input logic pg_s,
  input logic pwr_on_n,
  input logic bus_rst_n,
  input logic cfg_ready
);
  localparam int unsigned MIN_LO = (HOLD_CYC < PULSE_CYC) ? HOLD_CYC : PULSE_CYC;

  // Saturating run-length counters of each output level.
  logic [31:0] n_pwr_hi, n_pwr_lo, n_rst_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_pwr_hi <= '0;
      n_pwr_lo <= '0;
      n_rst_hi <= '0;
    end else begin
      n_pwr_hi <= !pwr_on_n ? '0 : (&n_pwr_hi ? n_pwr_hi : n_pwr_hi + 1'b1);
      n_pwr_lo <=  pwr_on_n ? '0 : (&n_pwr_lo ? n_pwr_lo : n_pwr_lo + 1'b1);
      n_rst_hi <= !bus_rst_n ? '0 : (&n_rst_hi ? n_rst_hi : n_rst_hi + 1'b1);
    end
  end

  // R3, R6: a bus reset release needs power-on released for the full wait.
  p_rst_after_pwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rst_n) |-> (pwr_on_n && n_pwr_hi >= REL_CYC));

  p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwr_on_n) && $past(pg_s)) |-> (n_rst_hi >= GAP_CYC && !bus_rst_n));

  // R5 (and the first hold): every power-on release follows a full low period.
  p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on_n) |-> (!bus_rst_n && n_pwr_lo >= MIN_LO));

  p_cfg_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_ready) |-> (n_rst_hi >= CFG_CYC));

  p_ready_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |-> (pwr_on_n && bus_rst_n));

  p_loss_asserts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s |=> (!pwr_on_n && !bus_rst_n && !cfg_ready));
endmodule

bind por_seq por_seq_chk #(
  .HOLD_CYC  (HOLD_CYC),
  .REL_CYC   (REL_CYC),
  .GAP_CYC   (GAP_CYC),
  .PULSE_CYC (PULSE_CYC),
  .CFG_CYC   (CFG_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pg_s      (pg_s),
  .pwr_on_n  (pwr_on_n),
  .bus_rst_n (bus_rst_n),
  .cfg_ready (cfg_ready)
);

// File: tb/sim_por_seq.sv
module sim_por_seq;
  localparam int KHZ = 1500;
  localparam int H_US = 3, R_US = 2, G_US = 5, P_US = 3, C_US = 4;

  // Expected cycle counts, ceiling written as quotient plus remainder flag (R9).
  localparam int E_HOLD  = (H_US*KHZ)/1000 + (((H_US*KHZ)%1000) != 0 ? 1 : 0);
  localparam int E_REL   = (R_US*KHZ)/1000 + (((R_US*KHZ)%1000) != 0 ? 1 : 0);
  localparam int E_GAP   = (G_US*KHZ)/1000 + (((G_US*KHZ)%1000) != 0 ? 1 : 0);
  localparam int E_PULSE = (P_US*KHZ)/1000 + (((P_US*KHZ)%1000) != 0 ? 1 : 0);
  localparam int E_CFG   = (C_US*KHZ)/1000 + (((C_US*KHZ)%1000) != 0 ? 1 : 0);
  localparam int SYNC = 2;
  localparam int B1 = E_HOLD + SYNC;
  localparam int B2 = B1 + E_REL;
  localparam int B3 = B2 + E_GAP;
  localparam int B4 = B3 + E_PULSE;
  localparam int B5 = B4 + E_REL;
  localparam int B6 = B5 + E_CFG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic pwr_on_n, bus_rst_n, cfg_ready;
  int   tests = 0;
  int   fails = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  por_seq #(
    .CLK_KHZ(KHZ), .HOLD_US(H_US), .REL_US(R_US),
    .GAP_US(G_US), .PULSE_US(P_US), .CFG_US(C_US)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .pwr_on_n(pwr_on_n), .bus_rst_n(bus_rst_n), .cfg_ready(cfg_ready)
  );

  wire [2:0] outv = {pwr_on_n, bus_rst_n, cfg_ready};

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected {pwr_on_n, bus_rst_n, cfg_ready} t edges after pwr_good rose.
  function automatic logic [2:0] exp_out(input int t);
    if (t < B1) return 3'b000;
    if (t < B2) return 3'b100;
    if (t < B3) return 3'b110;
    if (t < B4) return 3'b000;
    if (t < B5) return 3'b100;
    if (t < B6) return 3'b110;
    return 3'b111;
  endfunction

  function automatic string phase_req(input int t);
    if (t < B1) return "R2";
    if (t < B2) return "R3";
    if (t < B3) return "R4";
    if (t < B4) return "R5";
    if (t < B5) return "R6";
    return "R7";
  endfunction

  function automatic logic pick(input int w);
    case (w)
      0: return pwr_on_n;
      1: return bus_rst_n;
      default: return cfg_ready;
    endcase
  endfunction

  // Counts rising clock edges until the chosen output reaches val.
  task automatic edges_until(input int w, input logic val, output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (pick(w) != val && n < 500);
  endtask

  task automatic run_full();
    int n;
    pwr_good = 1'b1;
    edges_until(0, 1'b1, n);
    chk("R2 hold to power-on release", n, E_HOLD + SYNC);
    chk("R9 rounded hold count", E_HOLD, 5);
    chk("R3 bus reset still low at power-on release", bus_rst_n, 0);
    edges_until(1, 1'b1, n);
    chk("R3 release wait", n, E_REL);
    edges_until(0, 1'b0, n);
    chk("R4 gap length", n, E_GAP);
    chk("R4 bus reset pulled low with power-on", bus_rst_n, 0);
    edges_until(0, 1'b1, n);
    chk("R5 second pulse width", n, E_PULSE);
    chk("R5 bus reset low through pulse", bus_rst_n, 0);
    edges_until(1, 1'b1, n);
    chk("R6 second release wait", n, E_REL);
    chk("R7 ready low before settling", cfg_ready, 0);
    edges_until(2, 1'b1, n);
    chk("R7 settling delay", n, E_CFG);
    repeat (20) @(negedge clk);
    chk("R7 ready persists", outv, 3'b111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs during reset", outv, 3'b000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 outputs after reset, no power-good", outv, 3'b000);

    run_full();

    // Drop power-good at every cycle of the sequence.
    for (int d = 1; d <= B6 + 3; d++) begin
      pwr_good = 1'b0;
      repeat (6) @(negedge clk);
      chk("R8 outputs low after loss", outv, 3'b000);
      pwr_good = 1'b1;
      repeat (d) @(negedge clk);
      chk(phase_req(d), outv, exp_out(d));
      pwr_good = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 two-flop delay before loss acts", outv, exp_out(d + 2));
      @(negedge clk);
      chk("R8 loss on third edge", outv, 3'b000);
    end

    pwr_good = 1'b0;
    repeat (6) @(negedge clk);
    run_full();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule